// File: doc/BRIEF.md
# Multi-Port Scoreboard Computation Unit

This block is the front-end controller placed between a scoreboard's dependency logic and one execution pipeline. When it is idle it accepts an issued operation and becomes busy. It latches a mask of the source operands it needs (up to three) and a mask of the results it will produce (up to two). For every operand it needs, it raises a separate read request. When that operand's go-read grant arrives it captures the operand from its own slot of the read data bus. Grants arrive in any order, any mix, or all in one cycle.

When every needed operand has been read, the unit offers the operands to the pipeline over a valid/ready handshake. It then waits for the pipeline's result. After that it raises one write request per needed result and drives each result on its own slot of the write data bus until the matching go-write grant arrives. When it has no result to produce, it skips the pipeline and retires right after its reads. A read-release flag gates all read requests, so an idle unit, or one with nothing left to read, never asks for a read port. All requests come from registers, so a priority picker's grant never forms a combinational loop back into a request.

Top module: `mp_comp_unit`

## Requirements
- R1: `issue_i` sampled while idle makes `busy_o` high from the next cycle until retirement; `issue_i` sampled while busy has no effect on the latched masks or on the outstanding requests.
- R2: The cycle after an accepted issue, `rd_req_o` equals the issued read mask. Each request bit stays high until its `go_rd_i` bit is sampled high, and drops in the following cycle.
- R3: On a grant of read request k, the unit captures `rd_data_i[k*DW +: DW]`. That value appears on `pipe_opnd_o[k*DW +: DW]`, whatever the order or grouping of the grants.
- R4: While any read request is outstanding, `pipe_valid_o` is low and `wr_req_o` is zero.
- R5: When reads are complete and results are expected, `pipe_valid_o` rises and holds until `pipe_ready_i` is sampled high. It is low afterwards, and the result is captured on the first `res_valid_i` after the handshake.
- R6: The cycle after the result is captured, `wr_req_o` equals the issued write mask and `wr_data_o[j*DW +: DW]` shows `res_data_i[j*DW +: DW]` for each masked j. Each write request drops the cycle after its `go_wr_i` bit is sampled high.
- R7: `busy_o` stays high until every masked write has been granted (unmasked results count as written). It then falls, and `done_o` pulses high for exactly one cycle as `busy_o` falls.
- R8: With a zero write mask, `pipe_valid_o` never rises, and `busy_o` falls with a `done_o` pulse two cycles after the last read grant (one cycle after the last request drops).
- R9: `rd_rel_o` is high exactly while the busy unit still has a read outstanding. It is low when idle and never rises for a zero read mask. No read request is raised without it.
- R10: A go-read or go-write on a line with no outstanding request changes neither the requests nor the captured operand of that slot.
- R11: After reset, `busy_o`, `done_o`, `rd_rel_o`, `pipe_valid_o`, `rd_req_o` and `wr_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Issue strobe for a new operation |
| rd_mask_i | input | NRD | Operands needed by the issued operation |
| wr_mask_i | input | NWR | Results produced by the issued operation |
| busy_o | output | 1 | Unit holds an operation |
| done_o | output | 1 | One-cycle retirement pulse |
| rd_rel_o | output | 1 | Read-release: reads still outstanding |
| rd_req_o | output | NRD | Per-operand read requests |
| go_rd_i | input | NRD | Per-operand read grants |
| rd_data_i | input | NRD*DW | Operand data, one DW slot per operand |
| pipe_valid_o | output | 1 | Operands offered to pipeline |
| pipe_ready_i | input | 1 | Pipeline accepts operands |
| pipe_opnd_o | output | NRD*DW | Captured operands |
| res_valid_i | input | 1 | Pipeline result valid |
| res_data_i | input | NWR*DW | Pipeline results, one DW slot per result |
| wr_req_o | output | NWR | Per-result write requests |
| go_wr_i | input | NWR | Per-result write grants |
| wr_data_o | output | NWR*DW | Result data, one DW slot per result |

## Verification
Operations are issued with full, sparse and empty read and write masks. Their grants come all in one cycle, in ascending order or in descending order. This separates a correct per-operand capture from one that assumes a fixed order or simultaneous grants. The empty-write cases show whether the pipeline is bypassed, and the empty-read cases show whether the read-release suppresses requests. Directed cases cover an issue while busy, stray grants on unrequested lines and a stalled pipeline ready, which would expose a request reload, a wrong capture or a dropped valid.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [2:0] {
    CU_IDLE  = 3'd0,
    CU_READ  = 3'd1,
    CU_SEND  = 3'd2,
    CU_WAIT  = 3'd3,
    CU_WRITE = 3'd4
  } cu_phase_t;

  function automatic logic phase_busy(input cu_phase_t ph);
    return ph != CU_IDLE;
  endfunction
endpackage

// File: rtl/cu_read_port.sv
module cu_read_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          need,
  input  logic          go,
  input  logic [DW-1:0] din,
  output logic          pend,
  output logic [DW-1:0] opnd
);
  logic grant_hit;
  assign grant_hit = go & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      opnd <= '0;
    end else begin
      if (load)           pend <= need;
      else if (grant_hit) pend <= 1'b0;
      if (grant_hit)      opnd <= din;
    end
  end
endmodule

// File: rtl/cu_write_port.sv
module cu_write_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          need,
  input  logic          go,
  input  logic [DW-1:0] din,
  output logic          pend,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      dout <= '0;
    end else begin
      if (load)           pend <= need;
      else if (go & pend) pend <= 1'b0;
      if (load & need)    dout <= din;
    end
  end
endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import cu_pkg::*;
#(
  parameter int NRD = 3,
  parameter int NWR = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic [NRD-1:0] rd_mask_i,
  input  logic [NWR-1:0] wr_mask_i,
  input  logic [NRD-1:0] rd_pend,
  input  logic [NRD-1:0] rd_left,
  input  logic [NWR-1:0] wr_pend,
  input  logic           pipe_ready_i,
  input  logic           res_valid_i,
  output cu_phase_t      phase,
  output logic [NWR-1:0] wr_need,
  output logic           rd_rel,
  output logic           done,
  output logic           issue_accept,
  output logic           reads_done,
  output logic           res_capture,
  output logic           retire
);
  logic has_wr;
  assign has_wr       = |wr_need;
  assign issue_accept = (phase == CU_IDLE) && issue_i;
  assign reads_done   = (phase == CU_READ) && (rd_pend == '0);
  assign res_capture  = (phase == CU_WAIT) && res_valid_i;
  assign retire       = (reads_done && !has_wr) ||
                        ((phase == CU_WRITE) && (wr_pend == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= CU_IDLE;
      wr_need <= '0;
      rd_rel  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= retire;
      unique case (phase)
        CU_IDLE: if (issue_i) begin
          phase   <= CU_READ;
          wr_need <= wr_mask_i;
          rd_rel  <= |rd_mask_i;
        end
        CU_READ: begin
          if (rd_left == '0) rd_rel <= 1'b0;
          if (reads_done)    phase  <= has_wr ? CU_SEND : CU_IDLE;
        end
        CU_SEND:  if (pipe_ready_i)    phase <= CU_WAIT;
        CU_WAIT:  if (res_valid_i)     phase <= CU_WRITE;
        CU_WRITE: if (wr_pend == '0)   phase <= CU_IDLE;
        default:                       phase <= CU_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mp_comp_unit.sv
module mp_comp_unit
  import cu_pkg::*;
#(
  parameter int NRD = 3,
  parameter int NWR = 2,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [NRD-1:0]    rd_mask_i,
  input  logic [NWR-1:0]    wr_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_rel_o,
  output logic [NRD-1:0]    rd_req_o,
  input  logic [NRD-1:0]    go_rd_i,
  input  logic [NRD*DW-1:0] rd_data_i,
  output logic              pipe_valid_o,
  input  logic              pipe_ready_i,
  output logic [NRD*DW-1:0] pipe_opnd_o,
  input  logic              res_valid_i,
  input  logic [NWR*DW-1:0] res_data_i,
  output logic [NWR-1:0]    wr_req_o,
  input  logic [NWR-1:0]    go_wr_i,
  output logic [NWR*DW-1:0] wr_data_o
);
  cu_phase_t      phase;
  logic [NRD-1:0] rd_pend, rd_left;
  logic [NWR-1:0] wr_pend, wr_need;
  logic           rd_rel, done;
  logic           issue_accept, reads_done, res_capture, retire;

  assign rd_left = rd_pend & ~go_rd_i;

  cu_ctrl #(.NRD(NRD), .NWR(NWR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i),
    .rd_mask_i(rd_mask_i), .wr_mask_i(wr_mask_i),
    .rd_pend(rd_pend), .rd_left(rd_left), .wr_pend(wr_pend),
    .pipe_ready_i(pipe_ready_i), .res_valid_i(res_valid_i),
    .phase(phase), .wr_need(wr_need), .rd_rel(rd_rel), .done(done),
    .issue_accept(issue_accept), .reads_done(reads_done),
    .res_capture(res_capture), .retire(retire)
  );

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    cu_read_port #(.DW(DW)) u_rd (
      .clk(clk), .rst_n(rst_n), .load(issue_accept), .need(rd_mask_i[k]),
      .go(go_rd_i[k]), .din(rd_data_i[k*DW +: DW]),
      .pend(rd_pend[k]), .opnd(pipe_opnd_o[k*DW +: DW])
    );
  end

  for (genvar j = 0; j < NWR; j++) begin : g_wr
    cu_write_port #(.DW(DW)) u_wr (
      .clk(clk), .rst_n(rst_n), .load(res_capture), .need(wr_need[j]),
      .go(go_wr_i[j]), .din(res_data_i[j*DW +: DW]),
      .pend(wr_pend[j]), .dout(wr_data_o[j*DW +: DW])
    );
  end

  assign rd_req_o     = rd_pend & {NRD{rd_rel}};
  assign wr_req_o     = wr_pend;
  assign rd_rel_o     = rd_rel;
  assign busy_o       = phase_busy(phase);
  assign done_o       = done;
  assign pipe_valid_o = (phase == CU_SEND);
endmodule

// File: rtl/cu_checker.sv
module cu_checker #(
  parameter int NRD = 3,
  parameter int NWR = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           issue_accept,
  input logic           retire,
  input logic           busy_o,
  input logic           done_o,
  input logic           rd_rel_o,
  input logic [NRD-1:0] rd_req_o,
  input logic [NRD-1:0] go_rd_i,
  input logic [NWR-1:0] wr_req_o,
  input logic [NWR-1:0] go_wr_i,
  input logic           pipe_valid_o,
  input logic           pipe_ready_i
);
  assert_issue_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_accept |=> busy_o);

  assert_req_needs_rel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o != '0) |-> (rd_rel_o && busy_o));

  assert_idle_no_rel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_rel_o);

  assert_read_before_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o != '0) |-> (!pipe_valid_o && wr_req_o == '0));

  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_valid_o && !pipe_ready_i) |=> pipe_valid_o);

  assert_retire_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (done_o && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  for (genvar k = 0; k < NRD; k++) begin : g_rd_chk
    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o[k] && !go_rd_i[k]) |=> rd_req_o[k]);
    assert_rd_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o[k] && go_rd_i[k]) |=> !rd_req_o[k]);
  end

  for (genvar j = 0; j < NWR; j++) begin : g_wr_chk
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o[j] && !go_wr_i[j]) |=> wr_req_o[j]);
    assert_wr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o[j] && go_wr_i[j]) |=> !wr_req_o[j]);
  end
endmodule

bind mp_comp_unit cu_checker #(.NRD(NRD), .NWR(NWR)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_accept(issue_accept), .retire(retire),
  .busy_o(busy_o), .done_o(done_o), .rd_rel_o(rd_rel_o),
  .rd_req_o(rd_req_o), .go_rd_i(go_rd_i), .wr_req_o(wr_req_o),
  .go_wr_i(go_wr_i), .pipe_valid_o(pipe_valid_o), .pipe_ready_i(pipe_ready_i)
);

// File: tb/mp_comp_unit_test.sv
module mp_comp_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 3;
  localparam int NWR = 2;
  localparam int DW  = 16;
  localparam int NVEC = 9;
  // {rd_mask[14:12], wr_mask[11:10], order[9:8] (0 together, 1 up, 2 down), base[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {3'b111, 2'b11, 2'd0, 8'h11},
    {3'b111, 2'b11, 2'd1, 8'h22},
    {3'b111, 2'b11, 2'd2, 8'h33},
    {3'b101, 2'b01, 2'd1, 8'h44},
    {3'b010, 2'b10, 2'd2, 8'h55},
    {3'b000, 2'b11, 2'd0, 8'h66},
    {3'b110, 2'b00, 2'd1, 8'h77},
    {3'b000, 2'b00, 2'd0, 8'h88},
    {3'b011, 2'b11, 2'd2, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_i = 1'b0;
  logic [NRD-1:0] rd_mask_i = '0;
  logic [NWR-1:0] wr_mask_i = '0;
  logic busy_o, done_o, rd_rel_o, pipe_valid_o;
  logic [NRD-1:0] rd_req_o;
  logic [NRD-1:0] go_rd_i = '0;
  logic [NRD*DW-1:0] rd_data_i = '0;
  logic pipe_ready_i = 1'b0;
  logic [NRD*DW-1:0] pipe_opnd_o;
  logic res_valid_i = 1'b0;
  logic [NWR*DW-1:0] res_data_i = '0;
  logic [NWR-1:0] wr_req_o;
  logic [NWR-1:0] go_wr_i = '0;
  logic [NWR*DW-1:0] wr_data_o;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] exp_opnd [NRD];

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_comp_unit #(.NRD(NRD), .NWR(NWR), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rd_mask_i(rd_mask_i),
    .wr_mask_i(wr_mask_i), .busy_o(busy_o), .done_o(done_o), .rd_rel_o(rd_rel_o),
    .rd_req_o(rd_req_o), .go_rd_i(go_rd_i), .rd_data_i(rd_data_i),
    .pipe_valid_o(pipe_valid_o), .pipe_ready_i(pipe_ready_i),
    .pipe_opnd_o(pipe_opnd_o), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .wr_req_o(wr_req_o), .go_wr_i(go_wr_i), .wr_data_o(wr_data_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] opnd_val(input logic [7:0] base, input int k);
    return {base, 8'h01 + 8'(k)};
  endfunction

  function automatic logic [DW-1:0] res_val(input logic [7:0] base, input int j);
    return {~base, 8'hA0 + 8'(j)};
  endfunction

  task automatic run_op(input logic [2:0] rdm, input logic [1:0] wrm,
                        input logic [1:0] ord, input logic [7:0] base,
                        input bit stray);
    logic [2:0] left;
    logic [1:0] wleft;
    int wait_n;
    for (int k = 0; k < NRD; k++) rd_data_i[k*DW +: DW] = opnd_val(base, k);
    issue_i = 1'b1; rd_mask_i = rdm; wr_mask_i = wrm;
    tick();
    issue_i = 1'b0;
    chk(busy_o === 1'b1, "R1 busy after issue", 32'(busy_o), 32'd1);
    chk(rd_req_o === rdm, "R2 requests follow read mask", 32'(rd_req_o), 32'(rdm));
    chk(rd_rel_o === (|rdm), "R9 release at issue", 32'(rd_rel_o), 32'(|rdm));
    if (stray && rdm != 3'b111) begin
      rd_data_i[1*DW +: DW] = 16'hDEAD;
      go_rd_i = ~rdm;
      tick();
      go_rd_i = '0;
      rd_data_i[1*DW +: DW] = opnd_val(base, 1);
      chk(rd_req_o === rdm, "R10 stray go-read ignored", 32'(rd_req_o), 32'(rdm));
    end
    left = rdm;
    if (rdm != '0) begin
      if (ord == 2'd0) begin
        chk(wr_req_o === '0 && pipe_valid_o === 1'b0, "R4 quiet while reading",
            32'({wr_req_o, pipe_valid_o}), 32'd0);
        go_rd_i = rdm;
        tick();
        go_rd_i = '0;
        for (int k = 0; k < NRD; k++) if (rdm[k]) exp_opnd[k] = opnd_val(base, k);
        left = '0;
        chk(rd_req_o === '0, "R2 all requests drop together", 32'(rd_req_o), 32'd0);
      end else begin
        for (int i = 0; i < NRD; i++) begin
          int k;
          k = (ord == 2'd2) ? (NRD - 1 - i) : i;
          if (rdm[k]) begin
            chk(wr_req_o === '0 && pipe_valid_o === 1'b0, "R4 quiet while reading",
                32'({wr_req_o, pipe_valid_o}), 32'd0);
            go_rd_i = 3'(1 << k);
            tick();
            go_rd_i = '0;
            exp_opnd[k] = opnd_val(base, k);
            left[k] = 1'b0;
            chk(rd_req_o === left, "R2 granted request drops, others held",
                32'(rd_req_o), 32'(left));
          end
        end
      end
    end
    chk(rd_rel_o === 1'b0, "R9 release low after reads", 32'(rd_rel_o), 32'd0);
    if (wrm == '0) begin
      chk(pipe_valid_o === 1'b0 && busy_o === 1'b1, "R8 still busy, no valid",
          32'({pipe_valid_o, busy_o}), 32'd1);
      tick();
      chk(busy_o === 1'b0 && done_o === 1'b1 && pipe_valid_o === 1'b0,
          "R8 done right after reads", 32'({busy_o, done_o, pipe_valid_o}), 32'b010);
      tick();
      chk(done_o === 1'b0, "R7 done is one pulse", 32'(done_o), 32'd0);
      return;
    end
    wait_n = 0;
    while (pipe_valid_o !== 1'b1 && wait_n < 8) begin
      chk(wr_req_o === '0, "R4 no write before pipeline", 32'(wr_req_o), 32'd0);
      tick();
      wait_n++;
    end
    chk(pipe_valid_o === 1'b1, "R5 valid after reads", 32'(pipe_valid_o), 32'd1);
    for (int k = 0; k < NRD; k++)
      chk(pipe_opnd_o[k*DW +: DW] === exp_opnd[k], "R3 operand slot",
          32'(pipe_opnd_o[k*DW +: DW]), 32'(exp_opnd[k]));
    tick();
    chk(pipe_valid_o === 1'b1, "R5 valid held without ready", 32'(pipe_valid_o), 32'd1);
    pipe_ready_i = 1'b1;
    tick();
    pipe_ready_i = 1'b0;
    chk(pipe_valid_o === 1'b0 && wr_req_o === '0, "R5 valid drops after accept",
        32'({pipe_valid_o, wr_req_o}), 32'd0);
    for (int j = 0; j < NWR; j++) res_data_i[j*DW +: DW] = res_val(base, j);
    res_valid_i = 1'b1;
    tick();
    res_valid_i = 1'b0;
    res_data_i = '0;
    chk(wr_req_o === wrm, "R6 write requests follow write mask", 32'(wr_req_o), 32'(wrm));
    for (int j = 0; j < NWR; j++)
      if (wrm[j])
        chk(wr_data_o[j*DW +: DW] === res_val(base, j), "R6 result slot",
            32'(wr_data_o[j*DW +: DW]), 32'(res_val(base, j)));
    if (stray && wrm != 2'b11) begin
      go_wr_i = ~wrm;
      tick();
      go_wr_i = '0;
      chk(wr_req_o === wrm, "R10 stray go-write ignored", 32'(wr_req_o), 32'(wrm));
    end
    wleft = wrm;
    if (ord == 2'd0) begin
      go_wr_i = wrm;
      tick();
      go_wr_i = '0;
      wleft = '0;
    end else begin
      for (int i = 0; i < NWR; i++) begin
        int j;
        j = (ord == 2'd2) ? (NWR - 1 - i) : i;
        if (wrm[j]) begin
          chk(busy_o === 1'b1, "R7 busy until last write", 32'(busy_o), 32'd1);
          go_wr_i = 2'(1 << j);
          tick();
          go_wr_i = '0;
          wleft[j] = 1'b0;
          chk(wr_req_o === wleft, "R6 granted write drops", 32'(wr_req_o), 32'(wleft));
        end
      end
    end
    chk(wr_req_o === '0 && busy_o === 1'b1, "R7 busy in cycle after last grant",
        32'({wr_req_o, busy_o}), 32'd1);
    tick();
    chk(busy_o === 1'b0 && done_o === 1'b1, "R7 retire with done",
        32'({busy_o, done_o}), 32'b01);
    tick();
    chk(done_o === 1'b0 && rd_rel_o === 1'b0, "R7 done one pulse, R9 idle release",
        32'({done_o, rd_rel_o}), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NRD; k++) exp_opnd[k] = '0;
    tick();
    tick();
    chk({busy_o, done_o, rd_rel_o, pipe_valid_o, rd_req_o, wr_req_o} === '0,
        "R11 reset state", 32'({busy_o, done_o, rd_rel_o, pipe_valid_o, rd_req_o, wr_req_o}), 32'd0);
    rst_n = 1'b1;
    tick();
    chk(busy_o === 1'b0 && rd_req_o === '0, "R11 idle after reset",
        32'({busy_o, rd_req_o}), 32'd0);

    for (int v = 0; v < NVEC; v++)
      run_op(VEC[v][14:12], VEC[v][11:10], VEC[v][9:8], VEC[v][7:0], 1'b0);

    // R10: stray grants on unrequested read and write lines
    run_op(3'b001, 2'b01, 2'd1, 8'hC3, 1'b1);

    // R1: issue while busy is ignored
    for (int k = 0; k < NRD; k++) rd_data_i[k*DW +: DW] = opnd_val(8'h5A, k);
    issue_i = 1'b1; rd_mask_i = 3'b011; wr_mask_i = 2'b00;
    tick();
    rd_mask_i = 3'b100; wr_mask_i = 2'b11;
    tick();
    issue_i = 1'b0;
    chk(rd_req_o === 3'b011, "R1 issue while busy ignored", 32'(rd_req_o), 32'b011);
    go_rd_i = 3'b011;
    tick();
    go_rd_i = '0;
    chk(rd_req_o === '0, "R2 requests cleared", 32'(rd_req_o), 32'd0);
    tick();
    chk(busy_o === 1'b0 && done_o === 1'b1, "R1 original write mask kept (no writes)",
        32'({busy_o, done_o}), 32'b01);
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule